// File: doc/BRIEF.md
# Fractional Microsecond Tick Generator

This block turns an oscillator clock whose frequency is not a whole number of megahertz into a one-cycle enable that fires, on average, once per microsecond. It does so with a rational divider. Each clock cycle adds a step (the divisor field plus one) to a phase accumulator. Each time the accumulator reaches a threshold (the dividend field plus one), the threshold is taken off and a tick is issued. The ticks are therefore spread as evenly as the ratio allows over a repeating pattern, rather than bunched as a plain prescaler would bunch them.

A free-running microsecond counter advances once per tick. Software sets the ratio and reads the counter through a simple synchronous register bus. Software also picks the ratio to suit the oscillator. Examples: 12 MHz gives 0x000B; 26 MHz gives 0x0019; 19.2 MHz gives 0x045F (5 ticks in 96 cycles); 38.4 MHz gives 0x04BF; 12.8 MHz gives 0x043F; 16.8 MHz gives 0x0453.

Top module: `usec_tick_gen`

## Requirements
- R1: After a synchronous active-high reset, the ratio register holds 0x000B, the counter holds zero, `tick_o` is low and `bus_rdata` is zero.
- R2: The ratio register sits at byte offset 0x14. Bits 7:0 hold the dividend minus one and bits 15:8 hold the divisor minus one. A write stores `bus_wdata[15:0]`, and a read returns the stored value zero-extended to 32 bits.
- R3: Let d = dividend+1 and s = divisor+1, with s < d. Count edges from the last ratio write or reset, which is edge 0. Then `tick_o` is high after edge k exactly when floor(k·s/d) differs from floor((k−1)·s/d).
- R4: When s ≥ d, `tick_o` is high after every edge that is not a ratio write or a reset, so the tick rate never exceeds the clock rate.
- R5: A write to the ratio register clears the phase accumulator. `tick_o` is low in the cycle after the write, and the pattern of R3 restarts from that edge.
- R6: The counter is read at byte offset 0x10. It increments by one on each edge at which `tick_o` is high and holds otherwise. It is zero-extended into `bus_rdata`.
- R7: The counter is CNT_W bits wide (32 by default) and wraps from all ones to zero.
- R8: A write to offset 0x10 or to any unmapped offset changes neither the counter nor the ratio, and it does not disturb the tick pattern. A read of an unmapped offset returns zero.
- R9: `bus_rdata` is registered. It shows the addressed value as it was before the edge that samples the read, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| tick_o | output | 1 | One-cycle microsecond enable, registered |

## Verification
`tick_o` and the counter have fixed timing. `tick_o` is registered, so it reflects the accumulation made at an edge just after that edge. The counter then takes a tick in at the following edge, and a counter read shows up in `bus_rdata` one edge after the read is sampled. The bench drives every input one time unit after a rising edge and checks every output one time unit after the next edge. Its reference model advances once per edge and, before that update, takes the read value from the model state that was current before the edge. This reproduces the one-cycle latency of the counter and of the read path without using anything inside the design.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;
  localparam int unsigned RATIO_FIELD_W = 8;
  localparam int unsigned RATIO_W       = 2 * RATIO_FIELD_W;

  typedef struct packed {
    logic [RATIO_FIELD_W-1:0] divisor_m1;
    logic [RATIO_FIELD_W-1:0] dividend_m1;
  } ratio_cfg_t;
endpackage

// File: rtl/usec_ratio_reg.sv
module usec_ratio_reg
  import usec_tick_pkg::*;
#(
  parameter int unsigned    ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] RATIO_ADDR = 8'h14,
  parameter logic [RATIO_W-1:0] RESET_VAL = 16'h000B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [RATIO_W-1:0] wr_value,
  output ratio_cfg_t        ratio_q,
  output logic              ratio_wr
);
  assign ratio_wr = bus_sel && bus_wr && (bus_addr == RATIO_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= ratio_cfg_t'(RESET_VAL);
    end else if (ratio_wr) begin
      ratio_q <= ratio_cfg_t'(wr_value);
    end
  end
endmodule

// File: rtl/usec_phase_acc.sv
module usec_phase_acc #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [FIELD_W-1:0] dividend_m1,
  input  logic [FIELD_W-1:0] divisor_m1,
  output logic               tick_q
);
  localparam int unsigned ACC_W = FIELD_W + 2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] thresh;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] acc_d;
  logic             tick_d;

  assign step   = ACC_W'(divisor_m1) + ACC_W'(1);
  assign thresh = ACC_W'(dividend_m1) + ACC_W'(1);
  assign sum    = acc_q + step;

  always_comb begin
    acc_d  = sum;
    tick_d = 1'b0;
    if (clear) begin
      acc_d  = '0;
      tick_d = 1'b0;
    end else if (step >= thresh) begin
      acc_d  = '0;
      tick_d = 1'b1;
    end else if (sum >= thresh) begin
      acc_d  = sum - thresh;
      tick_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [CNT_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (advance) begin
      count_q <= count_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/usec_read_port.sv
module usec_read_port
  import usec_tick_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       CNT_W      = 32,
  parameter logic [ADDR_W-1:0] RATIO_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] COUNT_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  ratio_cfg_t        ratio_q,
  input  logic [CNT_W-1:0]  count_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] count_ext;
  logic [DATA_W-1:0] ratio_ext;
  logic [DATA_W-1:0] rd_mux;

  generate
    if (CNT_W < DATA_W) begin : g_cnt_pad
      assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count_q};
    end else begin : g_cnt_trunc
      assign count_ext = count_q[DATA_W-1:0];
    end
    if (RATIO_W < DATA_W) begin : g_ratio_pad
      assign ratio_ext = {{(DATA_W-RATIO_W){1'b0}}, ratio_q};
    end else begin : g_ratio_trunc
      assign ratio_ext = ratio_q[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (bus_addr == COUNT_ADDR) begin
      rd_mux = count_ext;
    end else if (bus_addr == RATIO_ADDR) begin
      rd_mux = ratio_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_sel && !bus_wr) begin
      rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen
  import usec_tick_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 8,
  parameter int unsigned        DATA_W     = 32,
  parameter int unsigned        CNT_W      = 32,
  parameter logic [ADDR_W-1:0]  COUNT_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0]  RATIO_ADDR = 8'h14,
  parameter logic [RATIO_W-1:0] RATIO_RST  = 16'h000B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_o
);
  ratio_cfg_t       cfg_q;
  logic             cfg_wr;
  logic [CNT_W-1:0] count_q;

  usec_ratio_reg #(
    .ADDR_W    (ADDR_W),
    .RATIO_ADDR(RATIO_ADDR),
    .RESET_VAL (RATIO_RST)
  ) ratio_i (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_value (bus_wdata[RATIO_W-1:0]),
    .ratio_q  (cfg_q),
    .ratio_wr (cfg_wr)
  );

  usec_phase_acc #(
    .FIELD_W(RATIO_FIELD_W)
  ) acc_i (
    .clk        (clk),
    .rst        (rst),
    .clear      (cfg_wr),
    .dividend_m1(cfg_q.dividend_m1),
    .divisor_m1 (cfg_q.divisor_m1),
    .tick_q     (tick_o)
  );

  usec_counter #(
    .CNT_W(CNT_W)
  ) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .advance(tick_o),
    .count_q(count_q)
  );

  usec_read_port #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .RATIO_ADDR(RATIO_ADDR),
    .COUNT_ADDR(COUNT_ADDR)
  ) rd_i (
    .clk     (clk),
    .rst     (rst),
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .ratio_q (cfg_q),
    .count_q (count_q),
    .rdata_q (bus_rdata)
  );
endmodule

// File: rtl/usec_tick_gen_chk.sv
module usec_tick_gen_chk
  import usec_tick_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 8,
  parameter int unsigned        CNT_W      = 32,
  parameter logic [ADDR_W-1:0]  RATIO_ADDR = 8'h14,
  parameter logic [RATIO_W-1:0] RATIO_RST  = 16'h000B
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [RATIO_W-1:0] wr_low,
  input logic               tick_o,
  input logic [RATIO_W-1:0] cfg_bits,
  input logic [CNT_W-1:0]   count_bits
);
  logic is_cfg_wr;
  logic is_other_wr;
  logic saturated;

  assign is_cfg_wr   = bus_sel && bus_wr && (bus_addr == RATIO_ADDR);
  assign is_other_wr = bus_sel && bus_wr && (bus_addr != RATIO_ADDR);
  assign saturated   = cfg_bits[RATIO_W-1:RATIO_FIELD_W] >= cfg_bits[RATIO_FIELD_W-1:0];

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!tick_o && count_bits == '0 && cfg_bits == RATIO_RST));

  // R2
  a_r2_cfg_load: assert property (@(posedge clk) disable iff (rst)
    is_cfg_wr |=> cfg_bits == $past(wr_low));

  // R4
  a_r4_saturated_rate: assert property (@(posedge clk) disable iff (rst)
    (saturated && !is_cfg_wr) |=> tick_o);

  // R5
  a_r5_write_quiet: assert property (@(posedge clk) disable iff (rst)
    is_cfg_wr |=> !tick_o);

  // R6
  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> count_bits == $past(count_bits) + CNT_W'(1));

  // R6
  a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_o |=> $stable(count_bits));

  // R8
  a_r8_other_write: assert property (@(posedge clk) disable iff (rst)
    is_other_wr |=> $stable(cfg_bits));
endmodule

bind usec_tick_gen usec_tick_gen_chk #(
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .RATIO_ADDR(RATIO_ADDR),
  .RATIO_RST (RATIO_RST)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .wr_low    (bus_wdata[15:0]),
  .tick_o    (tick_o),
  .cfg_bits  (cfg_q),
  .count_bits(count_q)
);

// File: tb/usec_tick_gen_tb_top.sv
module usec_tick_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CNT_W   = 12;
  localparam int unsigned CNT_MASK = (1 << TB_CNT_W) - 1;
  localparam logic [7:0] A_CNT = 8'h10;
  localparam logic [7:0] A_CFG = 8'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model
  logic [15:0] m_cfg = 16'h000B;
  longint      m_k = 0;
  int unsigned m_cnt = 0;
  bit          m_tick = 1'b0;
  logic [31:0] m_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usec_tick_gen #(.CNT_W(TB_CNT_W)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .tick_o   (tick_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit sel, input bit wr, input logic [7:0] addr,
                     input logic [31:0] wd, input string rtag);
    bit is_rd, is_cfg_wr;
    longint s, d;
    string ttag, dtag;
    bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    is_rd     = sel && !wr;
    is_cfg_wr = sel && wr && (addr == A_CFG);
    if (is_rd) begin
      if (addr == A_CNT)      m_rdata = 32'(m_cnt);
      else if (addr == A_CFG) m_rdata = {16'h0, m_cfg};
      else                    m_rdata = '0;
    end
    @(posedge clk);
    #1;
    if (rst) begin
      m_cfg = 16'h000B; m_k = 0; m_cnt = 0; m_tick = 1'b0; m_rdata = '0;
      ttag = "R1";
    end else begin
      if (m_tick) m_cnt = (m_cnt + 1) & CNT_MASK;
      if (is_cfg_wr) begin
        m_cfg = wd[15:0]; m_k = 0; m_tick = 1'b0;
        ttag = "R5";
      end else begin
        m_k++;
        s = longint'(m_cfg[15:8]) + 1;
        d = longint'(m_cfg[7:0]) + 1;
        m_tick = ((m_k * s) / d) != (((m_k - 1) * s) / d);
        ttag = (s >= d) ? "R4" : "R3";
      end
    end
    check(tick_o == m_tick, ttag, longint'(tick_o), longint'(m_tick));
    if (rtag != "")        dtag = rtag;
    else if (!is_rd)       dtag = "R9";
    else if (addr == A_CNT) dtag = "R6";
    else if (addr == A_CFG) dtag = "R2";
    else                   dtag = "R8";
    check(bus_rdata == m_rdata, dtag, longint'(bus_rdata), longint'(m_rdata));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, 32'h0, "");
  endtask

  task automatic run_cfg(input logic [15:0] cfg, input int n);
    cyc(1'b1, 1'b1, A_CFG, {16'hA5C3, cfg}, "R5");
    for (int i = 0; i < n; i++) begin
      if (i % 7 == 3) cyc(1'b1, 1'b0, A_CNT, 32'h0, "R6");
      else            cyc(1'b0, 1'b0, 8'h00, 32'h0, "");
    end
    cyc(1'b1, 1'b0, A_CFG, 32'h0, "R2");
  endtask

  initial begin
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    // R1: reset values read back
    cyc(1'b1, 1'b0, A_CFG, 32'h0, "R1");
    cyc(1'b1, 1'b0, A_CNT, 32'h0, "R1");
    // R3: default 12:1 ratio
    idle(40);
    cyc(1'b1, 1'b0, A_CNT, 32'h0, "R6");
    // near-exhaustive sweep of small fields (R3, R4, R5)
    for (int dv = 0; dv < 8; dv++)
      for (int dd = 0; dd < 8; dd++)
        run_cfg({8'(dv), 8'(dd)}, 2 * (dd + 1) + 3);
    // representative oscillator ratios
    run_cfg(16'h000B, 60);
    run_cfg(16'h0019, 80);
    run_cfg(16'h045F, 400);
    run_cfg(16'h04BF, 420);
    run_cfg(16'h043F, 300);
    run_cfg(16'h0453, 360);
    run_cfg(16'h0A03, 40);
    // R8: writes elsewhere ignored, unmapped read is zero
    cyc(1'b1, 1'b1, 8'h14, 32'h0000_045F, "R5");
    idle(30);
    cyc(1'b1, 1'b1, A_CNT, 32'h0000_0ABC, "R8");
    cyc(1'b1, 1'b1, 8'h20, 32'h0000_0000, "R8");
    idle(20);
    cyc(1'b1, 1'b0, A_CNT, 32'h0, "R8");
    cyc(1'b1, 1'b0, A_CFG, 32'h0, "R8");
    cyc(1'b1, 1'b0, 8'h18, 32'h0, "R8");
    idle(5);
    // R5: rewrite same ratio mid-pattern restarts phase
    idle(17);
    cyc(1'b1, 1'b1, A_CFG, 32'h0000_045F, "R5");
    idle(50);
    // R7: tick every cycle, counter wraps
    cyc(1'b1, 1'b1, A_CFG, 32'h0000_0000, "R5");
    for (int i = 0; i < (1 << TB_CNT_W) + 300; i++) begin
      if (i % 5 == 0) cyc(1'b1, 1'b0, A_CNT, 32'h0, "R7");
      else            cyc(1'b0, 1'b0, 8'h00, 32'h0, "");
    end
    // R1: reset in the middle of activity
    rst = 1'b1;
    cyc(1'b1, 1'b0, A_CNT, 32'h0, "R1");
    cyc(1'b0, 1'b0, 8'h00, 32'h0, "R1");
    rst = 1'b0;
    cyc(1'b1, 1'b0, A_CFG, 32'h0, "R1");
    cyc(1'b1, 1'b0, A_CNT, 32'h0, "R1");
    idle(30);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule